// File: doc/BRIEF.md
# SD Card Host Register Front-End

This block is the software-visible face of an SD flash controller. It sits between a simple single-cycle bus slave port and a card-side transfer engine. Software programs the card address, a transfer size and a clock divider. A block of data passes through one data window, one bus word at a time, into or out of a local buffer. A write to the command register starts the engine.

Progress is reported in two ways. The status word carries a live byte count of the buffer together with busy and fault flags. A single level interrupt line is raised on completion, and also when software issues a command while an operation is still running. A read of status acknowledges the interrupt.

The engine side is a plain handshake. The block gives a one-cycle start pulse with the operation code. The engine answers with a done pulse that may carry a fault. The engine reaches the buffer through its own word-indexed port.

Top module: `sdhost_regs`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0, `eng_start` is 0 and `clk_div` is all ones (slowest setting).
- R2: Word offsets decode as 0 divider, 1 card address, 2 data window, 3 command, 4 transfer size, 5 status; offsets 6 and 7 read as 0. The divider, address and size registers read back what was written and drive `clk_div`, `eng_addr` and `eng_size`.
- R3: Each bus write to the data window stores the word at the buffer pointer and advances the pointer by one word. It also adds 4 to the byte count, which saturates at 512.
- R4: Each bus read of the data window returns the word at the buffer pointer and advances the pointer by one word. It also subtracts 4 from the byte count, which never goes below 0.
- R5: Writing code 1 (read) or 2 (write) to the command register while idle has four effects. `eng_start` pulses for exactly one cycle after the write edge, and `eng_op` shows the code. Status bit 31 (busy) is set. The buffer pointer returns to word 0.
- R6: Writing any other command code while idle is ignored: there is no start pulse, busy stays clear and `irq` stays low.
- R7: A command write while busy starts nothing and leaves busy and `eng_op` unchanged, but raises `irq`.
- R8: `eng_done` while busy clears busy and raises `irq`. For a read operation it also sets the byte count to the transfer size, limited to 512, and rewinds the pointer. `eng_done` while idle has no effect.
- R9: `eng_fault` given with `eng_done` sets status bit 30. The bit stays set until the next accepted command clears it.
- R10: `irq` is a level that stays high until a status read. Status bits 29:12 always read 0, and bits 11:0 hold the byte count.
- R11: Engine writes through the buffer port are the words the host later reads from the data window. Engine reads through the buffer port return the words the host wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt, done or error |
| clk_div | output | DIV_W | Card clock divider setting |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 2 | Operation code: 1 read, 2 write |
| eng_addr | output | CARD_AW | Card address |
| eng_size | output | 12 | Transfer size in bytes |
| eng_done | input | 1 | Engine completion pulse |
| eng_fault | input | 1 | Fault qualifier for `eng_done` |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_idx | input | IDX_W | Engine buffer word index |
| eng_buf_wdata | input | DATA_W | Engine buffer write data |
| eng_buf_rdata | output | DATA_W | Engine buffer read data |

## Verification
The assertions check the following on every cycle:
- a start pulse lasts one cycle and only happens with busy set;
- a command written while busy, or an illegal code written while idle, never starts the engine;
- completion always frees the block and raises the interrupt;
- the byte count never exceeds one block;
- a status read with no new cause drops the interrupt.

Only the bench scenarios can show the data path and the counts. They confirm that words come back in order across the host and engine ports, that the count saturates and floors at the right values, that the count is reloaded from the size register after a read, and that a fault survives until the next accepted command.

// File: rtl/sdhost_pkg.sv
package sdhost_pkg;
   localparam int REG_AW    = 3;
   localparam int CNT_W     = 12;
   localparam int BUSY_POS  = 31;
   localparam int FAULT_POS = 30;

   typedef enum logic [2:0] {
      RG_DIV  = 3'd0,
      RG_ADDR = 3'd1,
      RG_DATA = 3'd2,
      RG_CMD  = 3'd3,
      RG_SIZE = 3'd4,
      RG_STAT = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/sdhost_buffer.sv
module sdhost_buffer import sdhost_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 512,
   localparam int BPW        = DATA_W / 8,
   localparam int WORDS      = BLOCK_BYTES / BPW,
   localparam int IDX_W      = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              restart,
   input  logic              load_en,
   input  logic [CNT_W-1:0]  load_bytes,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_idx,
   input  logic [DATA_W-1:0] eng_wdata,
   output logic [DATA_W-1:0] eng_rdata,
   output logic [CNT_W-1:0]  byte_cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BLOCK_BYTES);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(BPW);

   logic [DATA_W-1:0] mem [WORDS];
   logic [IDX_W-1:0]  ptr;
   logic [CNT_W-1:0]  cnt_up, cnt_dn, cnt_ld;

   // host write is applied last, so it wins a same-word collision
   always_ff @(posedge clk) begin
      if (eng_we)  mem[eng_idx] <= eng_wdata;
      if (host_wr) mem[ptr]     <= host_wdata;
   end

   assign host_rdata = mem[ptr];
   assign eng_rdata  = mem[eng_idx];

   assign cnt_up = (byte_cnt >= FULL - STEP) ? FULL : byte_cnt + STEP;
   assign cnt_dn = (byte_cnt >= STEP) ? byte_cnt - STEP : '0;
   assign cnt_ld = (load_bytes > FULL) ? FULL : load_bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         byte_cnt <= '0;
      end else if (restart) begin
         ptr <= '0;
      end else if (load_en) begin
         ptr      <= '0;
         byte_cnt <= cnt_ld;
      end else if (host_wr) begin
         ptr      <= ptr + 1'b1;
         byte_cnt <= cnt_up;
      end else if (host_rd) begin
         ptr      <= ptr + 1'b1;
         byte_cnt <= cnt_dn;
      end
   end
endmodule

// File: rtl/sdhost_ctrl.sv
module sdhost_ctrl import sdhost_pkg::*; (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic cmd_ok,
   input  op_e  cmd_op,
   input  logic stat_rd,
   input  logic eng_done,
   input  logic eng_fault,
   output logic busy,
   output logic fault,
   output op_e  cur_op,
   output logic eng_start,
   output logic irq,
   output logic accept,
   output logic rd_complete
);
   logic reject, finish, done_pend, err_pend;

   assign accept      = cmd_wr && cmd_ok && !busy;
   assign reject      = cmd_wr && busy;
   assign finish      = eng_done && busy;
   assign rd_complete = finish && (cur_op == OP_RD);
   assign irq         = done_pend || err_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         fault     <= 1'b0;
         cur_op    <= OP_NONE;
         eng_start <= 1'b0;
         done_pend <= 1'b0;
         err_pend  <= 1'b0;
      end else begin
         eng_start <= accept;
         if (accept) begin
            busy   <= 1'b1;
            fault  <= 1'b0;
            cur_op <= cmd_op;
         end else if (finish) begin
            busy <= 1'b0;
            if (eng_fault) fault <= 1'b1;
         end
         if (finish)       done_pend <= 1'b1;
         else if (stat_rd) done_pend <= 1'b0;
         if (reject)       err_pend <= 1'b1;
         else if (stat_rd) err_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/sdhost_regs.sv
module sdhost_regs import sdhost_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 512,
   parameter int DIV_W       = 8,
   parameter int CARD_AW     = 32,
   localparam int IDX_W      = $clog2(BLOCK_BYTES / (DATA_W / 8))
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [REG_AW-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq,
   output logic [DIV_W-1:0]   clk_div,
   output logic               eng_start,
   output logic [1:0]         eng_op,
   output logic [CARD_AW-1:0] eng_addr,
   output logic [CNT_W-1:0]   eng_size,
   input  logic               eng_done,
   input  logic               eng_fault,
   input  logic               eng_buf_we,
   input  logic [IDX_W-1:0]   eng_buf_idx,
   input  logic [DATA_W-1:0]  eng_buf_wdata,
   output logic [DATA_W-1:0]  eng_buf_rdata
);
   localparam int WORDS = BLOCK_BYTES / (DATA_W / 8);

   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 32");
   end
   if ((WORDS & (WORDS - 1)) != 0) begin : g_bad_depth
      $error("BLOCK_BYTES must give a power-of-two word count");
   end
   if (BLOCK_BYTES >= (1 << CNT_W)) begin : g_bad_block
      $error("BLOCK_BYTES does not fit the status count field");
   end
   if (CARD_AW > DATA_W || DIV_W > DATA_W) begin : g_bad_reg
      $error("register wider than the data bus");
   end

   logic              wr, rd, cmd_ok;
   reg_sel_e          sel;
   logic [DIV_W-1:0]  div_q;
   logic [CARD_AW-1:0] addr_q;
   logic [CNT_W-1:0]  size_q, byte_cnt;
   logic              busy, fault, accept, rd_complete;
   op_e               cur_op;
   logic [DATA_W-1:0] host_rdata, stat_word;
   logic [31:0]       stat32;

   assign wr     = bus_sel && bus_we;
   assign rd     = bus_sel && !bus_we;
   assign sel    = reg_sel_e'(bus_addr);
   assign cmd_ok = (bus_wdata == DATA_W'(OP_RD)) || (bus_wdata == DATA_W'(OP_WR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '1;
         addr_q <= '0;
         size_q <= '0;
      end else if (wr) begin
         case (sel)
            RG_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
            RG_ADDR: addr_q <= bus_wdata[CARD_AW-1:0];
            RG_SIZE: size_q <= bus_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   sdhost_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (wr && sel == RG_CMD),
      .cmd_ok      (cmd_ok),
      .cmd_op      (op_e'(bus_wdata[1:0])),
      .stat_rd     (rd && sel == RG_STAT),
      .eng_done    (eng_done),
      .eng_fault   (eng_fault),
      .busy        (busy),
      .fault       (fault),
      .cur_op      (cur_op),
      .eng_start   (eng_start),
      .irq         (irq),
      .accept      (accept),
      .rd_complete (rd_complete)
   );

   sdhost_buffer #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (wr && sel == RG_DATA),
      .host_rd    (rd && sel == RG_DATA),
      .host_wdata (bus_wdata),
      .host_rdata (host_rdata),
      .restart    (accept),
      .load_en    (rd_complete),
      .load_bytes (size_q),
      .eng_we     (eng_buf_we),
      .eng_idx    (eng_buf_idx),
      .eng_wdata  (eng_buf_wdata),
      .eng_rdata  (eng_buf_rdata),
      .byte_cnt   (byte_cnt)
   );

   assign stat32 = {busy, fault, {(32 - 2 - CNT_W){1'b0}}, byte_cnt};

   if (DATA_W > 32) begin : g_wide_stat
      assign stat_word = {{(DATA_W - 32){1'b0}}, stat32};
   end else begin : g_plain_stat
      assign stat_word = stat32;
   end

   always_comb begin
      case (sel)
         RG_DIV:  bus_rdata = DATA_W'(div_q);
         RG_ADDR: bus_rdata = DATA_W'(addr_q);
         RG_DATA: bus_rdata = host_rdata;
         RG_CMD:  bus_rdata = DATA_W'(cur_op);
         RG_SIZE: bus_rdata = DATA_W'(size_q);
         RG_STAT: bus_rdata = stat_word;
         default: bus_rdata = '0;
      endcase
   end

   assign clk_div  = div_q;
   assign eng_op   = cur_op;
   assign eng_addr = addr_q;
   assign eng_size = size_q;
endmodule

// File: rtl/sdhost_regs_chk.sv
module sdhost_regs_chk import sdhost_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int BLOCK_BYTES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [REG_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              eng_start,
   input logic              eng_done,
   input logic              busy,
   input logic              irq,
   input logic [CNT_W-1:0]  byte_cnt
);
   logic cmd_wr, stat_rd, good_code;
   assign cmd_wr    = bus_sel && bus_we && bus_addr == 3'd3;
   assign stat_rd   = bus_sel && !bus_we && bus_addr == 3'd5;
   assign good_code = bus_wdata == DATA_W'(1) || bus_wdata == DATA_W'(2);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);
   a_r6_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy && !good_code) |=> (!eng_start && !busy));
   a_r7_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> (!eng_start && busy && irq));
   a_r8_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && busy) |=> (!busy && irq));
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= CNT_W'(BLOCK_BYTES));
   a_r10_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !eng_done && !cmd_wr) |=> !irq);
endmodule

bind sdhost_regs sdhost_regs_chk #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .eng_start (eng_start),
   .eng_done  (eng_done),
   .busy      (busy),
   .irq       (irq),
   .byte_cnt  (byte_cnt)
);

// File: tb/sim_sdhost_regs.sv
module sim_sdhost_regs;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_we;
   logic [2:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        irq, eng_start, eng_done, eng_fault, eng_buf_we;
   logic [7:0]  clk_div;
   logic [1:0]  eng_op;
   logic [31:0] eng_addr, eng_buf_wdata, eng_buf_rdata;
   logic [11:0] eng_size;
   logic [6:0]  eng_buf_idx;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdhost_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .clk_div(clk_div), .eng_start(eng_start), .eng_op(eng_op),
      .eng_addr(eng_addr), .eng_size(eng_size), .eng_done(eng_done),
      .eng_fault(eng_fault), .eng_buf_we(eng_buf_we), .eng_buf_idx(eng_buf_idx),
      .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic finish_op(input logic flt);
      @(negedge clk);
      eng_done = 1'b1; eng_fault = flt;
      @(negedge clk);
      eng_done = 1'b0; eng_fault = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 start", {31'd0, eng_start}, 32'd0);
      chk("R1 divider", {24'd0, clk_div}, 32'h0000_00FF);
      rd(3'd5, v);
      chk("R1 status", v, 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(3'd0, 32'd3);
      wr(3'd1, 32'h0000_1234);
      wr(3'd4, 32'd16);
      rd(3'd0, v); chk("R2 divider readback", v, 32'd3);
      rd(3'd1, v); chk("R2 address readback", v, 32'h0000_1234);
      rd(3'd4, v); chk("R2 size readback", v, 32'd16);
      rd(3'd6, v); chk("R2 unused offset", v, 32'd0);
      chk("R2 clk_div", {24'd0, clk_div}, 32'd3);
      chk("R2 eng_addr", eng_addr, 32'h0000_1234);
      chk("R2 eng_size", {20'd0, eng_size}, 32'd16);
   endtask

   task automatic t_fill();
      logic [31:0] v;
      for (int i = 0; i < 128; i++) begin
         wr(3'd2, 32'hA500_0000 + i);
         if (i == 0) begin
            rd(3'd5, v); chk("R3 count after one word", v, 32'd4);
         end
      end
      rd(3'd5, v); chk("R3 count full block", v, 32'd512);
      wr(3'd2, 32'hDEAD_BEEF);
      rd(3'd5, v); chk("R3 count saturates", v, 32'd512);
   endtask

   task automatic t_write_op();
      logic [31:0] v;
      wr(3'd3, 32'd2);
      chk("R5 start pulse", {31'd0, eng_start}, 32'd1);
      chk("R5 op code", {30'd0, eng_op}, 32'd2);
      @(negedge clk);
      chk("R5 pulse ends", {31'd0, eng_start}, 32'd0);
      eng_buf_idx = 7'd1;   #1 chk("R11 engine reads word 1", eng_buf_rdata, 32'hA500_0001);
      eng_buf_idx = 7'd127; #1 chk("R11 engine reads word 127", eng_buf_rdata, 32'hA500_007F);
      eng_buf_idx = 7'd0;   #1 chk("R11 engine reads wrapped word", eng_buf_rdata, 32'hDEAD_BEEF);
      wr(3'd3, 32'd1);
      chk("R7 no start while busy", {31'd0, eng_start}, 32'd0);
      chk("R7 error irq", {31'd0, irq}, 32'd1);
      chk("R7 op kept", {30'd0, eng_op}, 32'd2);
      rd(3'd5, v); chk("R5 busy in status", v, 32'h8000_0200);
      chk("R10 irq cleared by status read", {31'd0, irq}, 32'd0);
      finish_op(1'b0);
      chk("R8 done irq", {31'd0, irq}, 32'd1);
      rd(3'd5, v); chk("R8 busy cleared", v, 32'h0000_0200);
      chk("R10 irq cleared after done", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_read_op();
      logic [31:0] v;
      wr(3'd3, 32'd1);
      chk("R5 read start", {31'd0, eng_start}, 32'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         eng_buf_we = 1'b1; eng_buf_idx = 7'(i); eng_buf_wdata = 32'hC000_0000 + i;
      end
      @(negedge clk);
      eng_buf_we = 1'b0;
      finish_op(1'b1);
      rd(3'd5, v); chk("R9 fault and R8 loaded count", v, 32'h4000_0010);
      for (int i = 0; i < 4; i++) begin
         rd(3'd2, v); chk("R11 host reads engine data", v, 32'hC000_0000 + i);
         if (i == 0) begin
            rd(3'd5, v); chk("R4 count drops by 4", v, 32'h4000_000C);
         end
      end
      rd(3'd2, v);
      rd(3'd5, v); chk("R4 count floors at zero, R9 fault held", v, 32'h4000_0000);
      wr(3'd3, 32'd2);
      rd(3'd5, v); chk("R9 fault cleared by accepted command", v, 32'h8000_0000);
      finish_op(1'b0);
      rd(3'd5, v);
   endtask

   task automatic t_bad_cmd();
      logic [31:0] v;
      wr(3'd3, 32'd0);
      chk("R6 code 0 no start", {31'd0, eng_start}, 32'd0);
      wr(3'd3, 32'd3);
      chk("R6 code 3 no start", {31'd0, eng_start}, 32'd0);
      chk("R6 no irq", {31'd0, irq}, 32'd0);
      rd(3'd5, v); chk("R6 still idle", v, 32'd0);
      finish_op(1'b1);
      chk("R8 done while idle ignored", {31'd0, irq}, 32'd0);
      rd(3'd5, v); chk("R8 idle done leaves status", v, 32'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      eng_done = 1'b0; eng_fault = 1'b0; eng_buf_we = 1'b0; eng_buf_idx = '0;
      eng_buf_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_fill();
      t_write_op();
      t_read_op();
      t_bad_cmd();
      summary();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule